// File: doc/BRIEF.md
# Two-Strobe Transmit Word Queue

This block sits between a host bus and a serial transmitter. It stores up to eight 31-bit words waiting to be sent. The host writes each word in two parts over a shared 16-bit bus. A low-part strobe latches the first part, and a high-part strobe then completes the word and places it in the next free slot.

The serializer takes words out one at a time with a pop request. The oldest word is always shown on the output, and it is consumed on the clock edge where pop is high. A ready flag is high while nothing is queued. It drops on the first commit and rises again only after every queued word has been taken. Loads into a full queue are dropped without any error indication.

Top module: `dual_strobe_txq`

## Requirements
- R1: A synchronous active-high `rst` empties the queue and discards any half-loaded word. After the reset edge, `word_count` is 0, `tx_ready` is 1 and `word_valid` is 0.
- R2: A `ld_lo` pulse latches `bus_in[15:0]` as word bits [15:0]. A later `ld_hi` pulse, with `ld_lo` low, supplies `bus_in[14:0]` as word bits [30:16] and commits the whole word to the queue on that edge.
- R3: Words leave in the order they were committed. `word_out` shows the oldest stored word whenever `word_valid` is 1.
- R4: Repeated `ld_lo` pulses before a `ld_hi` replace the held low part, so the most recent one is the one used.
- R5: A `ld_hi` pulse with no low part held since the last commit or reset is ignored: the count and the queue contents do not change.
- R6: If `ld_lo` and `ld_hi` are high in the same cycle, only the low part is latched and no word is committed.
- R7: A commit while 8 words are stored (and no pop in that cycle) is dropped, and the stored words are left unchanged. The commit still consumes the held low part.
- R8: `pop` while the queue is empty is ignored, and `word_count` stays 0.
- R9: If a commit and a pop happen in the same cycle on a queue that is neither empty nor full, the count is unchanged and both operations take effect.
- R10: `tx_ready` is 1 exactly when `word_count` is 0. It goes low on the edge of the first commit and rises on the edge that pops the last word.
- R11: `word_count` never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 16 | Shared host data bus |
| ld_lo | input | 1 | Low-part load strobe |
| ld_hi | input | 1 | High-part load strobe; commits the word |
| pop | input | 1 | Serializer request to consume the oldest word |
| word_out | output | 31 | Oldest stored word |
| word_valid | output | 1 | High when at least one word is stored |
| word_count | output | 4 | Number of stored words, 0 to 8 |
| tx_ready | output | 1 | High when the queue is empty |

## Verification
On every cycle, the assertions check the following:
- the occupancy bound;
- that `tx_ready` agrees with the count;
- that a full-queue commit and an empty-queue pop leave the count alone;
- that a `ld_hi` with nothing held commits nothing;
- that a commit releases the held low part.

Whether the right bits reach `word_out` in the right order can only be shown by the bench's scoreboard scenarios. The same holds for which low part wins after repeated strobes, and for whether reset throws away a half-loaded word.

// File: rtl/txq_pkg.sv
package txq_pkg;
    parameter int DEPTH  = 8;
    parameter int WORD_W = 31;
    parameter int BUS_W  = 16;
    localparam int LO_W  = BUS_W;
    localparam int HI_W  = WORD_W - LO_W;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef struct packed {
        logic            held;
        logic [LO_W-1:0] lo;
    } stage_t;

    function automatic word_t join_parts(input logic [HI_W-1:0] hi, input logic [LO_W-1:0] lo);
        return {hi, lo};
    endfunction

    function automatic ptr_t ptr_step(input ptr_t p);
        return (p == ptr_t'(DEPTH - 1)) ? '0 : p + ptr_t'(1);
    endfunction
endpackage

// File: rtl/txq_stager.sv
module txq_stager
    import txq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus_in,
    input  logic             ld_lo,
    input  logic             ld_hi,
    output logic             commit,
    output word_t            commit_word
);
    stage_t st;

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else if (ld_lo)
            st <= '{held: 1'b1, lo: bus_in[LO_W-1:0]};
        else if (ld_hi)
            st.held <= 1'b0;
    end

    assign commit      = ld_hi && !ld_lo && st.held;
    assign commit_word = join_parts(bus_in[HI_W-1:0], st.lo);

    // R7
    commit_release_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !st.held);

    // R5
    orphan_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_hi && !ld_lo && !st.held) |-> !commit);
endmodule

// File: rtl/txq_store.sv
module txq_store
    import txq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  word_t push_word,
    input  logic  pop,
    output word_t head,
    output cnt_t  count,
    output logic  empty_flag
);
    word_t mem [DEPTH];
    ptr_t  wr_ptr, rd_ptr;
    cnt_t  count_nx;
    logic  push_ok, pop_ok;

    assign push_ok  = push && (count != cnt_t'(DEPTH));
    assign pop_ok   = pop && (count != '0);
    assign count_nx = count + cnt_t'(push_ok) - cnt_t'(pop_ok);
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            count      <= '0;
            empty_flag <= 1'b1;
        end else begin
            if (push_ok) wr_ptr <= ptr_step(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
            count      <= count_nx;
            empty_flag <= (count_nx == '0);
        end
    end

    // R11
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= cnt_t'(DEPTH));

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (count == cnt_t'(DEPTH) && push && !pop) |=> (count == cnt_t'(DEPTH)));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && pop && !push) |=> (count == '0));
endmodule

// File: rtl/dual_strobe_txq.sv
module dual_strobe_txq
    import txq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BUS_W-1:0]     bus_in,
    input  logic                 ld_lo,
    input  logic                 ld_hi,
    input  logic                 pop,
    output logic [WORD_W-1:0]    word_out,
    output logic                 word_valid,
    output logic [CNT_W-1:0]     word_count,
    output logic                 tx_ready
);
    logic  commit;
    word_t commit_word;

    txq_stager u_stage (
        .clk         (clk),
        .rst         (rst),
        .bus_in      (bus_in),
        .ld_lo       (ld_lo),
        .ld_hi       (ld_hi),
        .commit      (commit),
        .commit_word (commit_word)
    );

    txq_store u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (commit),
        .push_word  (commit_word),
        .pop        (pop),
        .head       (word_out),
        .count      (word_count),
        .empty_flag (tx_ready)
    );

    assign word_valid = (word_count != '0);

    // R10
    ready_tracks_count_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready == (word_count == '0));

    // R6
    dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_lo && ld_hi && !pop) |=> (word_count == $past(word_count)));
endmodule

// File: tb/sim_dual_strobe_txq.sv
module sim_dual_strobe_txq;
    logic        clk = 1'b0;
    logic        rst, ld_lo, ld_hi, pop;
    logic [15:0] bus_in;
    logic [30:0] word_out;
    logic        word_valid, tx_ready;
    logic [3:0]  word_count;

    int tests = 0, fails = 0;
    logic [30:0] expq[$];

    always #4 clk = ~clk;

    dual_strobe_txq u0 (
        .clk(clk), .rst(rst), .bus_in(bus_in), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .pop(pop), .word_out(word_out), .word_valid(word_valid),
        .word_count(word_count), .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ld_lo = 0; ld_hi = 0; pop = 0; rst = 0;
    endtask

    task automatic put_lo(input logic [15:0] v);
        @(negedge clk); ld_lo = 1; ld_hi = 0; pop = 0; bus_in = v;
        @(negedge clk); ld_lo = 0;
    endtask

    // commit high part; scoreboard records it if the model has room
    task automatic put_hi(input logic [15:0] v, input logic [15:0] lo, input bit expect_commit);
        @(negedge clk); ld_hi = 1; ld_lo = 0; pop = 0; bus_in = v;
        if (expect_commit && expq.size() < 8) expq.push_back({v[14:0], lo});
        @(negedge clk); ld_hi = 0;
    endtask

    task automatic load(input logic [30:0] w);
        put_lo(w[15:0]);
        put_hi({1'b0, w[30:16]}, w[15:0], 1'b1);
    endtask

    // monitor: compare head against scoreboard, then consume it
    task automatic take(input string req);
        logic [30:0] e;
        @(negedge clk);
        e = expq.pop_front();
        chk(word_valid === 1'b1, req, word_valid, 1);
        chk(word_out === e, req, word_out, e);
        pop = 1;
        @(negedge clk); pop = 0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1; ld_lo = 0; ld_hi = 0; pop = 0; bus_in = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(word_count == 0, "R1 count", word_count, 0);
        chk(tx_ready === 1'b1, "R1 ready", tx_ready, 1);
        chk(word_valid === 1'b0, "R1 valid", word_valid, 0);

        // R2 R3 R10: three words in, out in order
        load(31'h1234_5678);
        chk(tx_ready === 1'b0, "R10 ready low after commit", tx_ready, 0);
        load(31'h7ABC_DEF0);
        load(31'h0000_0001);
        chk(word_count == 3, "R2 count", word_count, 3);
        take("R3 order");
        take("R3 order");
        chk(tx_ready === 1'b0, "R10 ready still low", tx_ready, 0);
        take("R3 order");
        chk(tx_ready === 1'b1, "R10 ready after last pop", tx_ready, 1);

        // R8 pop on empty
        @(negedge clk); pop = 1;
        @(negedge clk); pop = 0;
        chk(word_count == 0, "R8 empty pop", word_count, 0);

        // R7 R11 fill eight, ninth dropped
        for (int i = 0; i < 9; i++) load(31'(32'h0101_0000 * (i + 1) + i));
        chk(word_count == 8, "R7 full count", word_count, 8);
        chk(expq.size() == 8, "R7 model", expq.size(), 8);
        for (int i = 0; i < 8; i++) take("R7 contents");
        chk(tx_ready === 1'b1, "R10 ready after drain", tx_ready, 1);

        // R5 orphan high strobe (held part consumed by last commit)
        put_hi(16'h7FFF, 16'h0, 1'b0);
        chk(word_count == 0, "R5 orphan ignored", word_count, 0);
        chk(tx_ready === 1'b1, "R5 ready", tx_ready, 1);

        // R4 last low part wins
        put_lo(16'hAAAA);
        put_lo(16'h5555);
        put_hi(16'h0123, 16'h5555, 1'b1);
        take("R4 latest low");

        // R6 simultaneous strobes: low captured, nothing committed
        @(negedge clk); ld_lo = 1; ld_hi = 1; bus_in = 16'hC3C3;
        @(negedge clk); ld_lo = 0; ld_hi = 0;
        chk(word_count == 0, "R6 no commit", word_count, 0);
        put_hi(16'h0042, 16'hC3C3, 1'b1);
        take("R6 captured low");

        // R9 push and pop together
        load(31'h1111_1111);
        load(31'h2222_2222);
        put_lo(16'hBEEF);
        @(negedge clk);
        chk(word_out === expq[0], "R9 head", word_out, expq[0]);
        ld_hi = 1; pop = 1; bus_in = 16'h0777;
        void'(expq.pop_front());
        expq.push_back({15'h0777, 16'hBEEF});
        @(negedge clk); ld_hi = 0; pop = 0;
        chk(word_count == 2, "R9 count kept", word_count, 2);
        take("R9 order");
        take("R9 order");

        // R1 reset discards queue and held low part
        load(31'h3333_3333);
        put_lo(16'h9999);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        expq.delete();
        chk(word_count == 0, "R1 reset clears", word_count, 0);
        chk(tx_ready === 1'b1, "R1 reset ready", tx_ready, 1);
        put_hi(16'h0001, 16'h0, 1'b0);
        chk(word_count == 0, "R1 held part discarded", word_count, 0);
        idle();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule